// File: doc/BRIEF.md
# Sequence-Keyed One-Time-Pad Prefetch Queue

Each processor on a shared snooping bus encrypts the cache lines it sends with a one-time pad. Every transaction on the bus advances a 64-bit transaction counter. All processors see all transactions, so every copy of the counter stays equal. The pad for a transaction is derived from a 256-bit process key and the counter value that the transaction will carry. Computing a pad takes several cycles. For that reason this block computes pads for the current counter value and the values just after it before they are needed, and stores them in a small table tagged by counter value.

When the bus arbiter grants ownership, the block looks up the pad whose tag equals the current counter value. It XORs that pad with the outgoing plaintext line and presents the ciphertext. The receiver holds the same counter and key, so it can compute the same pad and recover the line with the same XOR. If the pad is not ready yet, the block raises a stall until the mixer produces it.

The keyed hash is represented by a deterministic four-round placeholder mixer. The mixer is pipelined and accepts one new counter value per cycle.

Top module: `otp_prefetch_queue`

## Requirements
- R1: While `rst` is high at a clock edge, the counter and the key register are cleared to zero and the pad table is emptied. After that edge, `cipher_valid` and `stall` are low.
- R2: `seed_load` loads the counter from `seed_value` at the clock edge and discards every stored and in-flight pad.
- R3: A cycle with `snoop_txn` high and `seed_load` low increments the counter by exactly one. A cycle with neither signal high leaves the counter unchanged.
- R4: The pad for counter value `s` under key `k` is defined as follows. Let `x = k XOR {s,s,s,s}`. Then, for r = 1, 2, 3, 4 in turn, `x = rotl(x, 11) XOR (x >> 3) XOR {4{s + r}}`, where the shift is logical and the addition is 64-bit. The pad is the final `x`.
- R5: A request is served with `cipher_line = line XOR pad(key, counter)`. The counter used is the one current in the cycle the request is served. The line is the `plain_line` value sampled in the grant cycle. `cipher_valid` is high for one cycle, in the cycle after the request is served.
- R6: If the matching pad is already stored, the grant is served in its own cycle. `stall` stays low and `cipher_valid` rises in the next cycle.
- R7: If no matching pad exists, `stall` is high in every cycle that the request waits, and the sampled plaintext is held. The request is served in the cycle the mixer delivers the pad, including a pad that leaves the mixer in that same cycle. `stall` and `cipher_valid` are never high together.
- R8: `key_load` replaces the key with `key_value` and discards all stored and in-flight pads. Pads computed afterwards use the new key.
- R9: The table keeps only entries whose tag lies in the window from the counter to the counter plus DEPTH-1, modulo 2^64. At most one entry matches the counter. The results stay correct when the counter runs ahead of precomputation or wraps past all-ones.
- R10: The mixer takes one counter value per cycle. It issues consecutive values up to the counter plus DEPTH-1, and a free table slot always exists for a pad that arrives in the window. As a result, back-to-back transfers, each followed by one snooped transaction, never stall once the window is full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| seed_load | input | 1 | Load the counter with the boot-time seed |
| seed_value | input | 64 | Initial counter value |
| snoop_txn | input | 1 | One bus transaction observed this cycle |
| key_load | input | 1 | Replace the process key |
| key_value | input | 256 | New process key |
| grant | input | 1 | Bus ownership granted; plaintext valid this cycle |
| plain_line | input | 256 | Outgoing plaintext cache line |
| cipher_line | output | 256 | Encrypted line |
| cipher_valid | output | 1 | `cipher_line` valid this cycle |
| stall | output | 1 | Waiting request has no pad yet |

## Verification
A waiting grant can be served in the cycle the mixer delivers the missing pad. In that cycle, the lookup must take the pad from the mixer output before the pad reaches the table. The bench provokes this by loading a new key and granting right away. It checks that `stall` is high in the grant cycle and that the ciphertext, computed from the new key, arrives with `stall` low. The second overlap is table pruning against insertion: a run of back-to-back snoops and a wrap of the counter past all-ones advance the window while pads are being written, and later grants must still match exactly one pad.

// File: rtl/otpq_pkg.sv
package otpq_pkg;
    localparam int SEQ_W  = 64;
    localparam int LINE_W = 256;
    localparam int REP    = LINE_W / SEQ_W;
    localparam int ROT    = 11;
    localparam int SHR    = 3;

    typedef logic [SEQ_W-1:0]  seq_t;
    typedef logic [LINE_W-1:0] line_t;

    typedef struct packed {
        logic  valid;
        seq_t  tag;
        line_t pad;
    } pad_entry_t;

    typedef struct packed {
        logic  valid;
        seq_t  tag;
        line_t state;
    } mix_stage_t;

    function automatic line_t mix_seed(line_t key, seq_t tag);
        return key ^ {REP{tag}};
    endfunction

    function automatic line_t mix_round(line_t s, seq_t tag, int unsigned rnd);
        seq_t salt;
        salt = tag + seq_t'(rnd);
        return ((s << ROT) | (s >> (LINE_W - ROT))) ^ (s >> SHR) ^ {REP{salt}};
    endfunction
endpackage

// File: rtl/otpq_seq_tracker.sv
module otpq_seq_tracker
    import otpq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic seed_load,
    input  seq_t seed_value,
    input  logic snoop_txn,
    output seq_t seq
);
    always_ff @(posedge clk) begin
        if (rst)            seq <= '0;
        else if (seed_load) seq <= seed_value;
        else if (snoop_txn) seq <= seq + seq_t'(1);
    end

    AST_SEQ_SEED: assert property (@(posedge clk) disable iff (rst)
        seed_load |=> seq == $past(seed_value)); // R2
    AST_SEQ_STEP: assert property (@(posedge clk) disable iff (rst)
        (snoop_txn && !seed_load) |=> seq == $past(seq) + seq_t'(1)); // R3
    AST_SEQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!snoop_txn && !seed_load) |=> $stable(seq)); // R3
endmodule

// File: rtl/otpq_mixer.sv
module otpq_mixer
    import otpq_pkg::*;
#(
    parameter int MIX_LAT = 4
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  flush,
    input  logic  in_valid,
    input  seq_t  in_tag,
    input  line_t key,
    output logic  out_valid,
    output seq_t  out_tag,
    output line_t out_pad
);
    for (genvar k = 0; k < MIX_LAT; k++) begin : g_stage
        mix_stage_t st_d;
        mix_stage_t st_q;
        if (k == 0) begin : g_head
            always_comb begin
                st_d.valid = in_valid;
                st_d.tag   = in_tag;
                st_d.state = mix_round(mix_seed(key, in_tag), in_tag, 1);
            end
        end else begin : g_body
            always_comb begin
                st_d.valid = g_stage[k-1].st_q.valid;
                st_d.tag   = g_stage[k-1].st_q.tag;
                st_d.state = mix_round(g_stage[k-1].st_q.state,
                                       g_stage[k-1].st_q.tag, unsigned'(k + 1));
            end
        end
        always_ff @(posedge clk) begin
            if (rst || flush) st_q <= '0;
            else              st_q <= st_d;
        end
    end

    assign out_valid = g_stage[MIX_LAT-1].st_q.valid;
    assign out_tag   = g_stage[MIX_LAT-1].st_q.tag;
    assign out_pad   = g_stage[MIX_LAT-1].st_q.state;
endmodule

// File: rtl/otpq_pad_store.sv
module otpq_pad_store
    import otpq_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  flush,
    input  seq_t  cur_seq,
    input  logic  wr_valid,
    input  seq_t  wr_tag,
    input  line_t wr_pad,
    output logic  hit,
    output line_t hit_pad
);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    pad_entry_t ent [DEPTH];
    logic [DEPTH-1:0] keep, match, vld;
    logic [IDX_W-1:0] slot;
    logic found, wr_ok, byp;

    function automatic logic in_window(seq_t tag, seq_t base);
        seq_t d;
        d = tag - base;
        return d < seq_t'(DEPTH);
    endfunction

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            vld[i]   = ent[i].valid;
            keep[i]  = ent[i].valid && in_window(ent[i].tag, cur_seq);
            match[i] = keep[i] && (ent[i].tag == cur_seq);
        end
    end

    always_comb begin
        slot  = '0;
        found = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            if (!keep[i] && !found) begin
                slot  = IDX_W'(i);
                found = 1'b1;
            end
        end
    end

    assign wr_ok = wr_valid && !flush && in_window(wr_tag, cur_seq);
    assign byp   = wr_valid && (wr_tag == cur_seq);
    assign hit   = !flush && ((|match) || byp);

    always_comb begin
        hit_pad = byp ? wr_pad : '0;
        for (int i = 0; i < DEPTH; i++)
            if (match[i]) hit_pad = hit_pad | ent[i].pad;
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (rst || flush) begin
                ent[i].valid <= 1'b0;
            end else begin
                ent[i].valid <= keep[i];
                if (wr_ok && found && (slot == IDX_W'(i)))
                    ent[i] <= '{valid: 1'b1, tag: wr_tag, pad: wr_pad};
            end
        end
    end

    AST_SINGLE_MATCH: assert property (@(posedge clk) disable iff (rst)
        $onehot0(match)); // R9
    AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (rst)
        flush |=> vld == '0); // R8
    AST_SLOT_FREE: assert property (@(posedge clk) disable iff (rst)
        wr_ok |-> found); // R10
endmodule

// File: rtl/otp_prefetch_queue.sv
module otp_prefetch_queue
    import otpq_pkg::*;
#(
    parameter int DEPTH   = 8,
    parameter int MIX_LAT = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              seed_load,
    input  logic [SEQ_W-1:0]  seed_value,
    input  logic              snoop_txn,
    input  logic              key_load,
    input  logic [LINE_W-1:0] key_value,
    input  logic              grant,
    input  logic [LINE_W-1:0] plain_line,
    output logic [LINE_W-1:0] cipher_line,
    output logic              cipher_valid,
    output logic              stall
);
    seq_t  seq, next_issue, diff;
    line_t key_q, held_q, line_sel, hit_pad, mix_pad;
    logic  flush, behind, issue_valid, hit, pend_q, req_active, mix_valid;
    seq_t  mix_tag;

    assign flush = seed_load || key_load;

    otpq_seq_tracker u_seq (
        .clk(clk), .rst(rst), .seed_load(seed_load), .seed_value(seed_value),
        .snoop_txn(snoop_txn), .seq(seq)
    );

    assign diff        = next_issue - seq;
    assign behind      = diff[SEQ_W-1];
    assign issue_valid = !flush && !behind && (diff < seq_t'(DEPTH));

    always_ff @(posedge clk) begin
        if (rst)              next_issue <= '0;
        else if (seed_load)   next_issue <= seed_value;
        else if (key_load)    next_issue <= seq;
        else if (behind)      next_issue <= seq;
        else if (issue_valid) next_issue <= next_issue + seq_t'(1);
    end

    always_ff @(posedge clk) begin
        if (rst)           key_q <= '0;
        else if (key_load) key_q <= key_value;
    end

    otpq_mixer #(.MIX_LAT(MIX_LAT)) u_mix (
        .clk(clk), .rst(rst), .flush(flush),
        .in_valid(issue_valid), .in_tag(next_issue), .key(key_q),
        .out_valid(mix_valid), .out_tag(mix_tag), .out_pad(mix_pad)
    );

    otpq_pad_store #(.DEPTH(DEPTH)) u_store (
        .clk(clk), .rst(rst), .flush(flush), .cur_seq(seq),
        .wr_valid(mix_valid), .wr_tag(mix_tag), .wr_pad(mix_pad),
        .hit(hit), .hit_pad(hit_pad)
    );

    assign req_active = grant || pend_q;
    assign line_sel   = grant ? plain_line : held_q;
    assign stall      = req_active && !hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q       <= 1'b0;
            held_q       <= '0;
            cipher_valid <= 1'b0;
            cipher_line  <= '0;
        end else begin
            cipher_valid <= 1'b0;
            if (req_active && hit) begin
                cipher_line  <= line_sel ^ hit_pad;
                cipher_valid <= 1'b1;
                pend_q       <= 1'b0;
            end else if (req_active) begin
                pend_q <= 1'b1;
                held_q <= line_sel;
            end
        end
    end

    AST_STALL_EXCL: assert property (@(posedge clk) disable iff (rst)
        stall |-> !cipher_valid); // R7
    AST_CIPHER_HAS_REQ: assert property (@(posedge clk) disable iff (rst)
        cipher_valid |-> $past(req_active)); // R5
endmodule

// File: tb/test_otp_prefetch_queue.sv
`timescale 1ns/1ps
module test_otp_prefetch_queue;
    logic clk = 1'b0;
    logic rst;
    logic seed_load, snoop_txn, key_load, grant;
    logic [63:0]  seed_value;
    logic [255:0] key_value, plain_line, cipher_line;
    logic cipher_valid, stall;

    int checks = 0;
    int fails  = 0;
    logic [255:0] exp_q[$];
    logic [63:0]  seq_m;
    logic [255:0] key_m;

    always #2.5 clk = ~clk;

    otp_prefetch_queue i_otp_prefetch_queue (
        .clk(clk), .rst(rst), .seed_load(seed_load), .seed_value(seed_value),
        .snoop_txn(snoop_txn), .key_load(key_load), .key_value(key_value),
        .grant(grant), .plain_line(plain_line), .cipher_line(cipher_line),
        .cipher_valid(cipher_valid), .stall(stall)
    );

    // R4: pad model written from the requirement
    function automatic logic [255:0] ref_pad(logic [255:0] k, logic [63:0] s);
        logic [255:0] x;
        x = k ^ {s, s, s, s};
        for (int r = 1; r <= 4; r++)
            x = {x[244:0], x[255:245]} ^ {3'b000, x[255:3]} ^ {4{s + 64'(r)}};
        return x;
    endfunction

    task automatic check_bit(string req, logic got, logic exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got %0b expected %0b", req, got, exp);
        end
    endtask

    // monitor: scoreboard pop on every ciphertext
    always @(negedge clk) begin
        if (!rst && cipher_valid) begin
            check_bit("R7 stall low with cipher_valid", stall, 1'b0);
            checks++;
            if (exp_q.size() == 0) begin
                fails++;
                $display("FAIL R5 unexpected cipher got %h expected none", cipher_line);
            end else begin
                logic [255:0] e;
                e = exp_q.pop_front();
                if (cipher_line !== e) begin
                    fails++;
                    $display("FAIL R4/R5 cipher got %h expected %h", cipher_line, e);
                end
            end
        end
    end

    task automatic idle(int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic do_grant(logic [255:0] p, logic exp_stall);
        @(posedge clk); #1;
        grant = 1'b1;
        plain_line = p;
        exp_q.push_back(p ^ ref_pad(key_m, seq_m));
        @(negedge clk);
        if (exp_stall) check_bit("R7 stall on missing pad", stall, 1'b1);
        else           check_bit("R6 no stall on ready pad", stall, 1'b0);
        @(posedge clk); #1;
        grant = 1'b0;
        plain_line = '0;
        if (!exp_stall) begin
            @(negedge clk);
            check_bit("R5 cipher_valid next cycle", cipher_valid, 1'b1);
        end
        while (exp_q.size() != 0) @(negedge clk);
        // own transfer is a bus transaction: R3 advance
        @(posedge clk); #1 snoop_txn = 1'b1;
        @(posedge clk); #1 snoop_txn = 1'b0;
        seq_m = seq_m + 64'd1;
    endtask

    task automatic load_seed(logic [63:0] s);
        @(posedge clk); #1 seed_load = 1'b1; seed_value = s;
        @(posedge clk); #1 seed_load = 1'b0;
        seq_m = s;
    endtask

    task automatic load_key(logic [255:0] k);
        @(posedge clk); #1 key_load = 1'b1; key_value = k;
        @(posedge clk); #1 key_load = 1'b0;
        key_m = k;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL R7 watchdog got hung run expected completion");
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

    initial begin
        rst = 1'b1; seed_load = 0; snoop_txn = 0; key_load = 0; grant = 0;
        seed_value = '0; key_value = '0; plain_line = '0;
        seq_m = '0; key_m = '0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        check_bit("R1 cipher_valid after reset", cipher_valid, 1'b0);
        check_bit("R1 stall after reset", stall, 1'b0);

        // R1/R4: zero key, counter zero
        idle(20);
        do_grant({8{32'hdeadbeef}}, 1'b0);

        // R2/R3: seeded counter, several patterns
        load_seed(64'h1234abcd0000001e);
        idle(20);
        do_grant({256{1'b1}}, 1'b0);
        do_grant({64{4'ha}}, 1'b0);
        do_grant({16{16'h0123}}, 1'b0);

        // R9: counter runs ahead of precomputation
        @(posedge clk); #1 snoop_txn = 1'b1;
        repeat (20) @(posedge clk);
        #1 snoop_txn = 1'b0;
        seq_m = seq_m + 64'd20;
        idle(20);
        do_grant({4{64'h0f1e2d3c4b5a6978}}, 1'b0);

        // R7/R8: key change then immediate grant; pad arrives via mixer bypass
        load_key({4{64'hc0ffee0012345678}});
        do_grant({8{32'h55aa33cc}}, 1'b1);

        // R6/R10: back-to-back transfers once the window is full
        idle(20);
        for (int i = 0; i < 10; i++)
            do_grant({8{32'(i * 32'h01010101 + 7)}}, 1'b0);

        // R9: window across counter wrap
        load_seed(64'hffff_ffff_ffff_fffd);
        idle(20);
        for (int i = 0; i < 5; i++)
            do_grant({4{64'(i) ^ 64'h8000_0000_0000_0001}}, 1'b0);

        idle(5);
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end
endmodule